// File: doc/BRIEF.md
# Two-Stage Pipelined 16-bit Core with Branch Delay Slot

This block is a small 16-bit register-machine core. It is split into two pipeline stages with one pipeline register between them. In the first stage, the core takes the word returned by a synchronous instruction memory and decodes it. In the second stage, it reads the operands from an eight-entry register file, evaluates the ALU and writes the result back.

While one instruction executes, the next sequential instruction is fetched and decoded. Once the pipeline is full, the core completes one instruction per clock.

- **Register moves.** There is no separate register-to-register path. A move is an ALU operation that passes its source operand through unchanged.
- **Branches and jumps.** They resolve in the execute stage and never flush the pipeline. The instruction after a branch, in its delay slot, always completes. The fetch after the delay slot comes from the target.
- **Debug port.** Every register-file write is reported on the debug port in the cycle the writing instruction is in execute. A bench or a trace unit uses it to observe architectural progress.

Top module: `duo_core`

## Requirements
- R1: While reset is high, the instruction address output is 0. After reset, the pipeline register holds a NOP, all eight registers read 0 and the zero flag is clear. The instruction at address 0 is the first to be fetched once reset falls.
- R2: Instruction words are 16 bits wide, with these fields:
  - opcode in bits 15:12;
  - destination register in bits 11:9;
  - first source in bits 8:6;
  - second source in bits 5:3;
  - a 6-bit immediate in bits 5:0, sign-extended.
- R3: The ALU opcodes and their results are below. All arithmetic wraps modulo 2^16, and the result is written to the destination.
  - 1 (add): rd = rs + rt.
  - 2 (subtract): rd = rs − rt.
  - 3 (and): rd = rs & rt.
  - 4 (or): rd = rs | rt.
  - 5 (xor): rd = rs ^ rt.
  - 6 (add immediate): rd = rs + sext(imm).
- R4: Timing of instructions:
  - An instruction held in the fetch stage in cycle k reports its register write in cycle k+1.
  - In the first cycle after reset, the core is fetching address 0.
  - Straight-line code completes one instruction per clock.
- R5: Opcode 7 (move) writes the first source to the destination unchanged. The second-source field is ignored.
- R6: The zero flag is set when the result of an ALU opcode (1 to 6) is zero, and cleared otherwise. A move, NOP, branch, jump or unused opcode leaves the flag unchanged.
- R7: Opcode 8 (branch on zero) is taken when the zero flag is set, with target = its own address + sext(bits 8:0). Opcode 9 (jump) is always taken, with target = its own address + sext(bits 11:0).
- R8: The instruction right after a branch or jump always executes, whether or not the branch is taken. The target instruction executes in the very next cycle after it, with no flush and no bubble.
- R9: An instruction can read a register written by the instruction immediately before it and receives the new value, without a stall.
- R10: Opcode 0 (NOP, the all-zero word) and opcodes 10 to 15 write no register, change no flag and do not redirect fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | AW | Address to the synchronous instruction memory; its word returns one edge later |
| imem_rdata | input | 16 | Instruction word for the address presented at the previous edge |
| dbg_we | output | 1 | A register-file write happens at the end of this cycle |
| dbg_waddr | output | 3 | Register being written |
| dbg_wdata | output | 16 | Value being written |

## Verification
On every cycle, the bound checker verifies the following:
- the fetch address advances by one or jumps to the resolved target;
- the delay-slot instruction follows a redirect into execute;
- a move reproduces its source operand and leaves the flag alone;
- NOPs stay silent;
- the address is zero during reset.

Several properties can only be shown by the directed programs in the bench: the exact write cycle of each instruction, ALU results, flag-based branch decisions, correct targets in both directions, the skipped instructions after a taken branch, and back-to-back dependencies. These tests compare the ordered trace of debug writes against hand-derived expectations.

// File: rtl/duo_pkg.sv
package duo_pkg;
  localparam int DATA_W = 16;
  localparam int INSN_W = 16;
  localparam int REG_AW = 3;
  localparam int NREG   = 1 << REG_AW;
  localparam int IMM_W  = 6;
  localparam int BOFF_W = 9;
  localparam int JOFF_W = 12;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_ADDI = 4'd6,
    OP_MOV  = 4'd7,
    OP_BZ   = 4'd8,
    OP_JMP  = 4'd9
  } op_e;

  typedef struct packed {
    op_e                 op;
    logic [REG_AW-1:0]   rd;
    logic [REG_AW-1:0]   rs;
    logic [REG_AW-1:0]   rt;
    logic [IMM_W-1:0]    imm;
    logic [BOFF_W-1:0]   boff;
    logic [JOFF_W-1:0]   joff;
  } dec_t;

  localparam dec_t DEC_NOP = '{op: OP_NOP, rd: '0, rs: '0, rt: '0,
                               imm: '0, boff: '0, joff: '0};

  function automatic logic [DATA_W-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(DATA_W-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic logic is_alu(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_XOR) || (op == OP_ADDI);
  endfunction

  // Result of the shared ALU; a move simply forwards operand a.
  function automatic logic [DATA_W-1:0] alu_eval(input op_e op,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input logic [DATA_W-1:0] k);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_ADDI: return a + k;
      OP_MOV:  return a;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/duo_fetch.sv
module duo_fetch #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redirect,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] fpc,
  output logic [AW-1:0] imem_addr
);
  logic [AW-1:0] fpc_next;

  assign fpc_next  = redirect ? target : fpc + AW'(1);
  // In reset the memory keeps reading word 0 so it is ready when reset falls.
  assign imem_addr = rst ? '0 : fpc_next;

  always_ff @(posedge clk) begin
    if (rst) fpc <= '0;
    else     fpc <= fpc_next;
  end
endmodule

// File: rtl/duo_decode.sv
module duo_decode
  import duo_pkg::*;
(
  input  logic [INSN_W-1:0] word,
  output dec_t              dec
);
  always_comb begin
    dec.rd   = word[11:9];
    dec.rs   = word[8:6];
    dec.rt   = word[5:3];
    dec.imm  = word[IMM_W-1:0];
    dec.boff = word[BOFF_W-1:0];
    dec.joff = word[JOFF_W-1:0];
    if (word[15:12] <= 4'd9) dec.op = op_e'(word[15:12]);
    else                     dec.op = OP_NOP;
  end
endmodule

// File: rtl/duo_regfile.sv
module duo_regfile
  import duo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] ra_addr,
  input  logic [REG_AW-1:0] rb_addr,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                                 regs[g] <= '0;
      else if (we && waddr == REG_AW'(g))      regs[g] <= wdata;
    end
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
endmodule

// File: rtl/duo_execute.sv
module duo_execute
  import duo_pkg::*;
#(
  parameter int AW = 12
) (
  input  op_e               op,
  input  logic [REG_AW-1:0] rd,
  input  logic [IMM_W-1:0]  imm,
  input  logic [BOFF_W-1:0] boff,
  input  logic [JOFF_W-1:0] joff,
  input  logic [AW-1:0]     pc,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              zflag,
  output logic              we,
  output logic [REG_AW-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              z_we,
  output logic              z_val,
  output logic              taken,
  output logic [AW-1:0]     target
);
  logic [DATA_W-1:0] res;
  logic [AW-1:0]     disp;

  assign res   = alu_eval(op, a, b, sext_imm(imm));
  assign disp  = (op == OP_JMP) ? AW'($signed(joff)) : AW'($signed(boff));
  assign target = pc + disp;
  assign waddr = rd;
  assign wdata = res;
  assign z_val = (res == '0);

  always_comb begin
    we    = 1'b0;
    z_we  = 1'b0;
    taken = 1'b0;
    if (is_alu(op)) begin
      we   = 1'b1;
      z_we = 1'b1;
    end else if (op == OP_MOV) begin
      we = 1'b1;
    end else if (op == OP_BZ) begin
      taken = zflag;
    end else if (op == OP_JMP) begin
      taken = 1'b1;
    end
  end
endmodule

// File: rtl/duo_core.sv
module duo_core
  import duo_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic              clk,
  input  logic              rst,
  output logic [AW-1:0]     imem_addr,
  input  logic [INSN_W-1:0] imem_rdata,
  output logic              dbg_we,
  output logic [REG_AW-1:0] dbg_waddr,
  output logic [DATA_W-1:0] dbg_wdata
);
  // Fetch/decode stage
  logic [AW-1:0] fpc;
  dec_t          fd_dec;

  // Pipeline register into execute
  dec_t          ex_d;
  logic [AW-1:0] ex_pc;

  // Execute stage wires, named for the checker
  logic              taken;
  logic [AW-1:0]     target;
  logic [DATA_W-1:0] rf_a, rf_b;
  logic              wr_en, z_we, z_val;
  logic [REG_AW-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              zflag;
  op_e               ex_op;

  assign ex_op = ex_d.op;

  duo_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .redirect(taken), .target(target),
    .fpc(fpc), .imem_addr(imem_addr)
  );

  duo_decode u_dec (.word(imem_rdata), .dec(fd_dec));

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_d  <= DEC_NOP;
      ex_pc <= '0;
    end else begin
      ex_d  <= fd_dec;
      ex_pc <= fpc;
    end
  end

  duo_regfile u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .ra_addr(ex_d.rs), .rb_addr(ex_d.rt), .ra_data(rf_a), .rb_data(rf_b)
  );

  duo_execute #(.AW(AW)) u_ex (
    .op(ex_d.op), .rd(ex_d.rd), .imm(ex_d.imm), .boff(ex_d.boff),
    .joff(ex_d.joff), .pc(ex_pc), .a(rf_a), .b(rf_b), .zflag(zflag),
    .we(wr_en), .waddr(wr_addr), .wdata(wr_data), .z_we(z_we),
    .z_val(z_val), .taken(taken), .target(target)
  );

  always_ff @(posedge clk) begin
    if (rst)       zflag <= 1'b0;
    else if (z_we) zflag <= z_val;
  end

  assign dbg_we    = wr_en;
  assign dbg_waddr = wr_addr;
  assign dbg_wdata = wr_data;
endmodule

// File: rtl/duo_core_chk.sv
module duo_core_chk
  import duo_pkg::*;
#(
  parameter int AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     imem_addr,
  input logic [AW-1:0]     fpc,
  input logic [AW-1:0]     ex_pc,
  input logic              taken,
  input logic [AW-1:0]     target,
  input op_e               ex_op,
  input logic              zflag,
  input logic [DATA_W-1:0] rf_a,
  input logic              dbg_we,
  input logic [DATA_W-1:0] dbg_wdata
);
  // R1: memory reads word 0 throughout reset
  always @(negedge clk) begin
    if (rst) a_r1_reset_addr: assert (imem_addr == '0);
  end

  // R4: without a redirect fetch moves to the next word
  a_r4_fetch_advance: assert property (@(posedge clk) disable iff (rst)
    !taken |=> fpc == $past(fpc) + AW'(1));

  // R7: a taken branch steers fetch to its target
  a_r7_redirect: assert property (@(posedge clk) disable iff (rst)
    taken |=> fpc == $past(target));

  // R8: the slot instruction enters execute right after the branch
  a_r8_delay_slot: assert property (@(posedge clk) disable iff (rst)
    taken |=> ex_pc == $past(ex_pc) + AW'(1));

  // R5: a move writes its source operand unchanged
  a_r5_move_pass: assert property (@(posedge clk) disable iff (rst)
    ex_op == OP_MOV |-> dbg_we && dbg_wdata == rf_a);

  // R6: move and NOP keep the zero flag
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (ex_op == OP_MOV || ex_op == OP_NOP) |=> $stable(zflag));

  // R10: a NOP neither writes nor redirects
  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    ex_op == OP_NOP |-> !dbg_we && !taken);
endmodule

bind duo_core duo_core_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .fpc(fpc), .ex_pc(ex_pc),
  .taken(taken), .target(target), .ex_op(ex_op), .zflag(zflag),
  .rf_a(rf_a), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata)
);

// File: tb/sim_duo_core.sv
`timescale 1ns/1ps
module sim_duo_core;
  localparam int AW = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [15:0] imem_rdata;
  logic        dbg_we;
  logic [2:0]  dbg_waddr;
  logic [15:0] dbg_wdata;

  logic [15:0] mem [256];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int log_n;
  int log_a [64];
  int log_d [64];
  int log_c [64];

  always #2 clk = ~clk;

  always_ff @(posedge clk) imem_rdata <= mem[imem_addr[7:0]];

  duo_core #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dbg_we(dbg_we), .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata)
  );

  // Encoders follow the field layout of R2, R7.
  function automatic logic [15:0] e_r(int op, int rd, int rs, int rt);
    return {4'(op), 3'(rd), 3'(rs), 3'(rt), 3'b000};
  endfunction
  function automatic logic [15:0] e_i(int op, int rd, int rs, int imm);
    return {4'(op), 3'(rd), 3'(rs), 6'(imm)};
  endfunction
  function automatic logic [15:0] e_bz(int off);
    return {4'd8, 3'd0, 9'(off)};
  endfunction
  function automatic logic [15:0] e_j(int off);
    return {4'd9, 12'(off)};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  // Reset, release after a falling edge, then log debug writes per cycle.
  task automatic run(int ncyc);
    rst = 1'b1;
    log_n = 0;
    repeat (3) @(negedge clk);
    chk(imem_addr == '0, "R1", "address in reset", int'(imem_addr), 0);
    rst = 1'b0;
    #1;
    chk(dbg_we == 1'b0, "R1", "write in first cycle", int'(dbg_we), 0);
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      if (dbg_we && log_n < 64) begin
        log_a[log_n] = int'(dbg_waddr);
        log_d[log_n] = int'(dbg_wdata);
        log_c[log_n] = c;
        log_n++;
      end
    end
  endtask

  task automatic exp_w(int i, string req, int a, int d, int c);
    chk(log_a[i] == a, req, $sformatf("write %0d reg", i), log_a[i], a);
    chk(log_d[i] == d, req, $sformatf("write %0d data", i), log_d[i], d);
    chk(log_c[i] == c, req, $sformatf("write %0d cycle", i), log_c[i], c);
  endtask

  // R1 reset state: zero registers, clear flag, fetch starts at 0
  task automatic t_reset();
    clear_mem();
    mem[0] = e_bz(4);          // flag clear after reset: not taken
    mem[1] = e_r(7, 1, 5, 0);  // r1 <- r5 (0 after reset)
    mem[2] = e_i(6, 2, 0, 2);
    run(6);
    chk(log_n == 2, "R1", "write count", log_n, 2);
    exp_w(0, "R1", 1, 0, 2);
    exp_w(1, "R1", 2, 2, 3);
  endtask

  // R3 ALU results, R4 one per clock, R9 back-to-back dependency
  task automatic t_alu();
    clear_mem();
    mem[0] = e_i(6, 1, 0, 5);
    mem[1] = e_i(6, 2, 0, -3);
    mem[2] = e_r(1, 3, 1, 2);
    mem[3] = e_r(2, 4, 1, 2);
    mem[4] = e_r(3, 5, 1, 2);
    mem[5] = e_r(4, 6, 1, 2);
    mem[6] = e_r(5, 7, 1, 2);
    mem[7] = e_r(1, 1, 6, 4);  // wraps
    run(10);
    chk(log_n == 8, "R4", "write count", log_n, 8);
    exp_w(0, "R4", 1, 16'h0005, 1);
    exp_w(1, "R3", 2, 16'hFFFD, 2);
    exp_w(2, "R9", 3, 16'h0002, 3);
    exp_w(3, "R3", 4, 16'h0008, 4);
    exp_w(4, "R3", 5, 16'h0005, 5);
    exp_w(5, "R3", 6, 16'hFFFD, 6);
    exp_w(6, "R3", 7, 16'hFFF8, 7);
    exp_w(7, "R3", 1, 16'h0005, 8);
  endtask

  // R5 move passes source, second source ignored
  task automatic t_move();
    clear_mem();
    mem[0] = e_i(6, 1, 0, -1);
    mem[1] = e_r(7, 2, 1, 0);
    mem[2] = e_r(7, 3, 2, 0);
    mem[3] = e_r(7, 2, 7, 0);
    mem[4] = e_r(7, 5, 1, 7);
    run(7);
    chk(log_n == 5, "R5", "write count", log_n, 5);
    exp_w(1, "R5", 2, 16'hFFFF, 2);
    exp_w(2, "R5", 3, 16'hFFFF, 3);
    exp_w(3, "R5", 2, 16'h0000, 4);
    exp_w(4, "R5", 5, 16'hFFFF, 5);
  endtask

  // R6 flag sources, R7 branch on zero, R8 delay slot
  task automatic t_branch();
    clear_mem();
    mem[0]  = e_i(6, 1, 0, 1);   // flag 0
    mem[1]  = e_r(7, 2, 0, 0);   // zero value, flag kept
    mem[2]  = e_bz(4);           // not taken
    mem[3]  = e_i(6, 3, 0, 7);   // slot
    mem[4]  = e_i(6, 4, 0, 4);
    mem[5]  = e_r(2, 5, 1, 1);   // flag 1
    mem[6]  = 16'h0000;
    mem[7]  = e_bz(5);           // taken to 12
    mem[8]  = e_i(6, 6, 0, 9);   // slot
    mem[9]  = e_i(6, 7, 0, 11);  // skipped
    mem[12] = e_i(6, 7, 0, 12);
    run(14);
    chk(log_n == 7, "R8", "write count", log_n, 7);
    exp_w(1, "R6", 2, 0, 2);
    exp_w(2, "R6", 3, 7, 4);
    exp_w(3, "R7", 4, 4, 5);
    exp_w(4, "R6", 5, 0, 6);
    exp_w(5, "R8", 6, 9, 9);
    exp_w(6, "R8", 7, 12, 10);
  endtask

  // R7 jumps both directions, R8 slot after jump
  task automatic t_jump();
    clear_mem();
    mem[0] = e_j(5);
    mem[1] = e_i(6, 1, 0, 3);
    mem[2] = e_i(6, 2, 0, 2);    // skipped
    mem[3] = e_i(6, 4, 0, -32);
    mem[4] = 16'h0000;
    mem[5] = e_i(6, 2, 0, 6);
    mem[6] = e_j(-3);
    mem[7] = e_i(6, 3, 0, 1);
    run(8);
    chk(log_n == 5, "R7", "write count", log_n, 5);
    exp_w(0, "R8", 1, 3, 2);
    exp_w(1, "R7", 2, 6, 3);
    exp_w(2, "R8", 3, 1, 5);
    exp_w(3, "R7", 4, 16'hFFE0, 6);
  endtask

  // R10 unused opcodes do nothing; flag survives them
  task automatic t_unused();
    clear_mem();
    mem[0] = e_i(6, 1, 0, 0);    // flag 1
    mem[1] = 16'hFFFF;
    mem[2] = 16'hB123;
    mem[3] = 16'hA6C8;
    mem[4] = e_bz(4);            // taken to 8
    mem[5] = e_i(6, 2, 0, 1);
    mem[6] = e_i(6, 3, 0, 5);    // skipped
    mem[8] = e_i(6, 4, 0, 2);
    run(9);
    chk(log_n == 3, "R10", "write count", log_n, 3);
    exp_w(0, "R10", 1, 0, 1);
    exp_w(1, "R10", 2, 1, 6);
    exp_w(2, "R10", 4, 2, 7);
  endtask

  initial begin
    clear_mem();
    t_reset();
    t_alu();
    t_move();
    t_branch();
    t_jump();
    t_unused();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule